// File: doc/BRIEF.md
# Threshold-Qualified Programmable Event Counter

This block is one general-purpose event counter with its own 32-bit control word. Each cycle it picks one of several event flag buses, keeps only the flags enabled by a unit mask, and counts the flags that remain to get a per-cycle event count. That count is filtered by the current privilege mode. It then either goes straight into the accumulator or is reduced to a single qualified cycle by a threshold compare. The compare can be inverted and can be limited to rising edges of its result.

Software programs the control word and reads or presets the counter through a small register port. A counter write takes effect at the next clock edge. When the accumulator wraps past its top value, the block raises a one-cycle overflow pulse. Anything that consumes the pulse, such as interrupt delivery, sits outside this block.

Top module: `event_threshold_counter`

## Requirements
- R1: After reset the control word, the counter and the overflow output are all zero.
- R2: The control word is read back unchanged at address 0. Its fields are: source select in bits 7:0, unit mask in 15:8, user enable in 16, kernel enable in 17, edge mode in 18, master enable in 22, invert in 23 and threshold in 31:24. Bits 21:19 are stored but have no effect. A control write applies from the next cycle.
- R3: The per-cycle event count is the number of set flags in source `select` that are also set in the unit mask (bit b of the mask gates flag b). A select value of NUM_SRC or above gives a count of zero.
- R4: With a threshold of zero, the counter adds the per-cycle event count every counted cycle, and the invert and edge bits have no effect.
- R5: With a nonzero threshold and invert clear, the counter adds one in each counted cycle whose event count is at least the threshold.
- R6: With a nonzero threshold and invert set, the counter adds one in each counted cycle whose event count is below the threshold.
- R7: With a nonzero threshold and edge mode set, the counter adds one only in a counted cycle where the condition is true and it was not true in a counted cycle just before. A cycle that is not counted resets this history.
- R8: A cycle is counted only when the user enable is set and priv_os is 0, or the kernel enable is set and priv_os is 1.
- R9: With the master enable clear, the counter holds its value.
- R10: A counter write (address 1) loads the written value and wins over any increment in the same cycle.
- R11: When an increment carries out of the counter's top bit, the counter keeps the wrapped low bits and overflow_o is high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_os | input | 1 | Current privilege mode: 1 kernel, 0 user |
| src_flags | input | NUM_SRC*FLAG_W | Event flag buses; source s occupies bits s*FLAG_W and up |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 control, 1 counter (read and write) |
| reg_wdata | input | DATA_W | Write data (control uses bits 31:0) |
| reg_rdata | output | DATA_W | Read data for reg_addr, zero-extended |
| overflow_o | output | 1 | One-cycle pulse after a wrap |

## Verification
The bench builds the block with a 16-bit counter, three sources and six flags per source. The narrow counter lets presets near the top value reach the wrap and the overflow pulse within a few cycles. Three sources leave select value 3 free to exercise the out-of-range case. Six flags give per-cycle counts up to 6, so thresholds from 1 to 7 cover both outcomes of the compare, including a threshold that can never be met.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

    localparam int CTL_W = 32;

    // control word, MSB first
    typedef struct packed {
        logic [7:0] thresh;
        logic       invert;
        logic       enable;
        logic [2:0] spare;
        logic       edge_det;
        logic       os_en;
        logic       usr_en;
        logic [7:0] umask;
        logic [7:0] evsel;
    } evctl_t;

    typedef enum logic {
        ADDR_CTL = 1'b0,
        ADDR_CNT = 1'b1
    } evaddr_e;

    function automatic logic mode_ok(evctl_t c, logic os);
        return c.enable & (os ? c.os_en : c.usr_en);
    endfunction

    function automatic logic thr_hit(logic [7:0] n, evctl_t c);
        return c.invert ? (n < c.thresh) : (n >= c.thresh);
    endfunction

endpackage

// File: rtl/evcnt_src_mux.sv
module evcnt_src_mux #(
    parameter int NUM_SRC = 4,
    parameter int FLAG_W  = 8,
    parameter int EVW     = 4
) (
    input  logic [NUM_SRC*FLAG_W-1:0] flags,
    input  logic [7:0]                sel,
    input  logic [7:0]                umask,
    output logic [EVW-1:0]            n
);

    function automatic logic [EVW-1:0] popc(logic [FLAG_W-1:0] v);
        logic [EVW-1:0] acc;
        acc = '0;
        for (int b = 0; b < FLAG_W; b++) acc = acc + EVW'(v[b]);
        return acc;
    endfunction

    logic [EVW-1:0] per_src [NUM_SRC];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign per_src[s] = popc(flags[s*FLAG_W +: FLAG_W] & umask[FLAG_W-1:0]);
    end

    always_comb begin
        n = '0;
        for (int s = 0; s < NUM_SRC; s++)
            if (sel == 8'(s)) n = per_src[s];
    end

endmodule

// File: rtl/evcnt_qualify.sv
module evcnt_qualify
    import evcnt_pkg::*;
#(
    parameter int EVW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  evctl_t         ctl,
    input  logic           priv_os,
    input  logic [EVW-1:0] n,
    output logic [EVW-1:0] inc
);

    logic active, cond, cond_q, zero_thr;

    assign active   = mode_ok(ctl, priv_os);
    assign zero_thr = (ctl.thresh == 8'd0);
    assign cond     = thr_hit(8'(n), ctl);

    // condition history, cleared by any uncounted cycle
    always_ff @(posedge clk) begin
        if (rst) cond_q <= 1'b0;
        else     cond_q <= active & cond;
    end

    always_comb begin
        if (!active)          inc = '0;
        else if (zero_thr)    inc = n;
        else if (ctl.edge_det) inc = EVW'(cond & ~cond_q);
        else                  inc = EVW'(cond);
    end

endmodule

// File: rtl/evcnt_accum.sv
module evcnt_accum #(
    parameter int CNT_W = 48,
    parameter int EVW   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [EVW-1:0]   inc,
    output logic [CNT_W-1:0] count_q,
    output logic             ovf_q
);

    logic [CNT_W:0] sum;
    assign sum = {1'b0, count_q} + (CNT_W+1)'(inc);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else if (wr) begin
            count_q <= wdata;
            ovf_q   <= 1'b0;
        end else begin
            count_q <= sum[CNT_W-1:0];
            ovf_q   <= sum[CNT_W];
        end
    end

endmodule

// File: rtl/event_threshold_counter.sv
module event_threshold_counter
    import evcnt_pkg::*;
#(
    parameter int CNT_W   = 48,
    parameter int NUM_SRC = 4,
    parameter int FLAG_W  = 8,
    parameter int EVW     = $clog2(FLAG_W + 1),
    parameter int DATA_W  = (CNT_W > CTL_W) ? CNT_W : CTL_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      priv_os,
    input  logic [NUM_SRC*FLAG_W-1:0] src_flags,
    input  logic                      reg_we,
    input  logic                      reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic                      overflow_o
);

    evctl_t           ctl_q;
    logic             ctl_wr, cnt_wr;
    logic [EVW-1:0]   ev_n, inc;
    logic [CNT_W-1:0] count_q;

    assign ctl_wr = reg_we && (evaddr_e'(reg_addr) == ADDR_CTL);
    assign cnt_wr = reg_we && (evaddr_e'(reg_addr) == ADDR_CNT);

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_wr) ctl_q <= evctl_t'(reg_wdata[CTL_W-1:0]);
    end

    evcnt_src_mux #(.NUM_SRC(NUM_SRC), .FLAG_W(FLAG_W), .EVW(EVW)) u_mux (
        .flags(src_flags), .sel(ctl_q.evsel), .umask(ctl_q.umask), .n(ev_n)
    );

    evcnt_qualify #(.EVW(EVW)) u_qual (
        .clk(clk), .rst(rst), .ctl(ctl_q), .priv_os(priv_os), .n(ev_n), .inc(inc)
    );

    evcnt_accum #(.CNT_W(CNT_W), .EVW(EVW)) u_acc (
        .clk(clk), .rst(rst), .wr(cnt_wr), .wdata(reg_wdata[CNT_W-1:0]),
        .inc(inc), .count_q(count_q), .ovf_q(overflow_o)
    );

    assign reg_rdata = (evaddr_e'(reg_addr) == ADDR_CNT) ? DATA_W'(count_q)
                                                         : DATA_W'(ctl_q);

endmodule

// File: rtl/evcnt_checker.sv
module evcnt_checker
    import evcnt_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int EVW   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_cnt,
    input logic [CNT_W-1:0] wdata,
    input evctl_t           ctl,
    input logic [CNT_W-1:0] count,
    input logic             ovf
);

    localparam logic [CNT_W-1:0] MAX_STEP = CNT_W'((1 << EVW) - 1);

    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> count == $past(wdata));

    p_no_ovf_after_write_r10: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> !ovf);

    p_hold_disabled_r9: assert property (@(posedge clk) disable iff (rst)
        (!wr_cnt && !ctl.enable) |=> count == $past(count));

    p_unit_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!wr_cnt && ctl.thresh != 8'd0) |=> CNT_W'(count - $past(count)) <= CNT_W'(1));

    p_step_bound_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_cnt |=> CNT_W'(count - $past(count)) <= MAX_STEP);

    p_ovf_wrapped_r11: assert property (@(posedge clk) disable iff (rst)
        ovf |-> count < MAX_STEP);

    p_ovf_single_r11: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf);

endmodule

bind event_threshold_counter evcnt_checker #(.CNT_W(CNT_W), .EVW(EVW)) u_chk (
    .clk(clk), .rst(rst), .wr_cnt(cnt_wr), .wdata(reg_wdata[CNT_W-1:0]),
    .ctl(ctl_q), .count(count_q), .ovf(overflow_o)
);

// File: tb/event_threshold_counter_test.sv
module event_threshold_counter_test;

    localparam int CW = 16;
    localparam int NS = 3;
    localparam int FW = 6;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            priv_os = 1'b0;
    logic [NS*FW-1:0] src_flags = '0;
    logic            reg_we = 1'b0;
    logic            reg_addr = 1'b1;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic            overflow_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] ctl_m = '0;
    logic [CW-1:0] exp_cnt = '0;
    logic exp_ovf = 1'b0;
    logic prev_m = 1'b0;

    always #10 clk = ~clk;

    event_threshold_counter #(.CNT_W(CW), .NUM_SRC(NS), .FLAG_W(FW)) uut (
        .clk(clk), .rst(rst), .priv_os(priv_os), .src_flags(src_flags),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .overflow_o(overflow_o)
    );

    task automatic chk(string tag, longint unsigned got, longint unsigned exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int unsigned ev_count(logic [NS*FW-1:0] f, logic [31:0] c);
        int unsigned sel = c[7:0];
        int unsigned k = 0;
        if (sel >= NS) return 0;
        for (int b = 0; b < FW; b++) k += (f[sel*FW+b] & c[8+b]) ? 1 : 0;
        return k;
    endfunction

    // one clock with model update, then check counter and overflow
    task automatic tick(string tag);
        int unsigned n, d, thr;
        logic act, hit;
        logic [CW:0] sum;
        n   = ev_count(src_flags, ctl_m);
        thr = ctl_m[31:24];
        act = ctl_m[22] && (priv_os ? ctl_m[17] : ctl_m[16]);
        hit = ctl_m[23] ? (n < thr) : (n >= thr);
        if (!act)          d = 0;
        else if (thr == 0) d = n;
        else if (ctl_m[18]) d = (hit && !prev_m) ? 1 : 0;
        else               d = hit ? 1 : 0;
        prev_m = act && hit;
        if (reg_we && reg_addr) begin
            exp_cnt = reg_wdata[CW-1:0];
            exp_ovf = 1'b0;
        end else begin
            sum = {1'b0, exp_cnt} + (CW+1)'(d);
            exp_cnt = sum[CW-1:0];
            exp_ovf = sum[CW];
        end
        if (reg_we && !reg_addr) ctl_m = reg_wdata[31:0];
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        reg_addr = 1'b1;
        #1;
        chk(tag, reg_rdata, DW'(exp_cnt));
        chk({tag, "/ovf"}, overflow_o, exp_ovf);
    endtask

    task automatic wr_ctl(logic [31:0] v, string tag);
        reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = v;
        tick(tag);
    endtask

    task automatic wr_cnt(logic [CW-1:0] v, string tag);
        reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = DW'(v);
        tick(tag);
    endtask

    function automatic logic [31:0] mkctl(int thr, bit inv, bit en, bit edg,
                                          bit os, bit usr, int um, int sel);
        return {8'(thr), inv, en, 3'b000, edg, os, usr, 8'(um), 8'(sel)};
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 count", reg_rdata, 0);
        chk("R1 ovf", overflow_o, 0);
        reg_addr = 1'b0; #1;
        chk("R1 ctl", reg_rdata, 0);
        reg_addr = 1'b1;

        // R2 readback with spare bits, enable clear so nothing counts
        wr_ctl(32'hA5B8_3F12, "R2");
        reg_addr = 1'b0; #1;
        chk("R2 readback", reg_rdata, 32'hA5B8_3F12);
        reg_addr = 1'b1;

        // R3 select and mask: src1 all ones, mask 0x0F -> 4 per cycle
        src_flags = '1;
        wr_ctl(mkctl(0, 0, 1, 0, 1, 1, 8'h0F, 1), "R3");
        repeat (3) tick("R3");
        src_flags = {6'b000000, 6'b101010, 6'b000000};
        repeat (2) tick("R3");
        wr_ctl(mkctl(0, 0, 1, 0, 1, 1, 8'hFF, 3), "R3");
        src_flags = '1;
        repeat (3) tick("R3 out of range");

        // R4 zero threshold ignores invert and edge
        wr_ctl(mkctl(0, 1, 1, 1, 1, 1, 8'h3F, 2), "R4");
        repeat (3) tick("R4");

        // R5 threshold 3, counts 3 and 2
        wr_ctl(mkctl(3, 0, 1, 0, 1, 1, 8'h07, 0), "R5");
        repeat (2) tick("R5");
        src_flags = {12'h0, 6'b000011};
        repeat (2) tick("R5");

        // R6 invert, threshold 1: zero-event cycles
        wr_ctl(mkctl(1, 1, 1, 0, 1, 1, 8'h3F, 0), "R6");
        src_flags = '0;
        repeat (3) tick("R6");
        src_flags = '1;
        tick("R6");

        // R7 edge mode
        wr_ctl(mkctl(2, 0, 1, 1, 1, 1, 8'h3F, 0), "R7");
        repeat (3) tick("R7 hold");
        src_flags = '0; tick("R7 low");
        src_flags = '1; repeat (2) tick("R7 rise");

        // R8 privilege filter
        src_flags = '1;
        wr_ctl(mkctl(0, 0, 1, 0, 0, 1, 8'h3F, 0), "R8");
        priv_os = 1'b1; repeat (2) tick("R8 kernel excluded");
        priv_os = 1'b0; repeat (2) tick("R8 user");
        wr_ctl(mkctl(0, 0, 1, 0, 1, 0, 8'h3F, 0), "R8");
        repeat (2) tick("R8 user excluded");
        priv_os = 1'b1; tick("R8 kernel");

        // R9 master enable clear
        wr_ctl(mkctl(0, 0, 0, 0, 1, 1, 8'h3F, 0), "R9");
        repeat (3) tick("R9");

        // R10 write wins over increment
        wr_ctl(mkctl(0, 0, 1, 0, 1, 1, 8'h3F, 0), "R10");
        wr_cnt(16'h1234, "R10");
        tick("R10");

        // R11 wrap and single overflow pulse
        wr_cnt(16'hFFFC, "R11");
        repeat (3) tick("R11");
        wr_cnt(16'hFFFF, "R11");
        src_flags = {12'h0, 6'b000001};
        repeat (2) tick("R11");

        // constrained random mix
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom_range(0, 99);
            priv_os   = 1'($urandom);
            src_flags = (NS*FW)'($urandom);
            if (r < 4) begin
                reg_we = 1'b1; reg_addr = 1'b0;
                reg_wdata = {5'($urandom_range(0, 7)), 27'($urandom)};
                reg_wdata[7:0] = 8'($urandom_range(0, 3));
                tick("R2 random ctl");
            end else if (r < 7) begin
                reg_we = 1'b1; reg_addr = 1'b1;
                reg_wdata = DW'(16'hFFF0 | 16'($urandom_range(0, 15)));
                tick("R10 random preset");
            end else begin
                tick("R5 random run");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule